// File: doc/BRIEF.md
# Eight-Channel DMA Channel Control Registers

This block is the software-visible control and status store for a set of DMA channels. Software reaches it over a simple 32-bit register bus. Each channel owns a 32-byte window that holds four registers: a mode word, an enable/status word, a residual count and a transfer address. A separate transfer engine reports progress to the block. Each decrement pulse consumes one unit of count and advances the address by the bus width. Error pulses latch sticky flags.

When a channel's count runs out, the block raises its terminal-count flag and drops the channel's enable. All sticky flags are cleared by writing ones to them. A single interrupt line summarises every channel whose interrupt enable is set and that holds any flag. Reads are combinational from the address lines. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `dmac_regfile`

## Requirements
- R1: After synchronous reset, every register of every channel reads 0 and `irq` is low.
- R2: Address bits [7:5] pick the channel. Bits [4:3] pick the register: 0 = mode (offset 0x00), 1 = enable/status (0x08), 2 = count (0x10), 3 = address (0x18). Bits [2:0] are ignored. A write changes only the addressed register of the addressed channel.
- R3: The mode register holds an access-time code in bits [1:0], interrupt enable in bit 2 and a width code in bits [4:3]. Width code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes. Bits [31:5] read 0.
- R4: In the enable/status register, bit 0 is the channel enable and bit 1 is the direction (1 = transfer into memory, 0 = out of memory). Both take the written value directly. Unused bits read 0.
- R5: Bit 8 (terminal count), bit 9 (memory error) and bit 10 (address error) are sticky. Writing 1 to one of these bits clears it. Writing 0 leaves it unchanged.
- R6: A memory-error or address-error event pulse sets the matching flag of its channel. The enable bit is not changed.
- R7: A decrement pulse on an enabled channel with a nonzero count lowers the count by 1 and raises the address by the width in bytes. The count register always reads the residual count.
- R8: A decrement pulse is ignored when the channel is disabled or its count is already 0.
- R9: A decrement that takes the count from 1 to 0 sets the terminal-count flag and clears the enable bit.
- R10: `irq` is high exactly when some channel has its interrupt enable set and at least one of its three flags set.
- R11: If an event sets a flag in the same cycle that software writes 1 to clear that flag, the flag ends up set.
- R12: A count write in the same cycle as a decrement cancels the whole decrement, so neither count nor address steps. An address write in the same cycle as a decrement overrides the address step. A terminal decrement clears the enable even if the same-cycle write sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dec_evt | input | 8 | Per-channel decrement pulse from the transfer engine |
| merr_evt | input | 8 | Per-channel memory-error pulse |
| aerr_evt | input | 8 | Per-channel address-error pulse |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of functions can fall in the same cycle:
- A hardware event setting a flag and a software write-one-to-clear of that same flag.
- A software write to the count, address or enable register and a decrement pulse on the same channel.

The bench provokes both by driving the bus write and the event pulse in one clock. It then reads the registers back through the bus. The flag must end up set. The written count or address must hold exactly, with no step. A terminal decrement must leave the enable clear.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int DATA_W   = 32;
    localparam int NCH_DEF  = 8;
    localparam int CNT_DEF  = 24;
    localparam int WIN_BITS = 5;   // 32-byte window per channel

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_ADDR  = 2'd3
    } reg_sel_e;

    // mode word, bits [4:0]
    typedef struct packed {
        logic [1:0] width;   // [4:3]
        logic       ie;      // [2]
        logic [1:0] atime;   // [1:0]
    } mode_t;

    // enable/status state, packed compactly; placed in the word by ctrl_word
    typedef struct packed {
        logic aerr;
        logic merr;
        logic tc;
        logic dir;
        logic en;
    } ctrl_t;

    localparam int BIT_EN   = 0;
    localparam int BIT_DIR  = 1;
    localparam int BIT_TC   = 8;
    localparam int BIT_MERR = 9;
    localparam int BIT_AERR = 10;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] mode_word(input mode_t m);
        return {{(DATA_W-5){1'b0}}, m};
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[BIT_EN]   = c.en;
        w[BIT_DIR]  = c.dir;
        w[BIT_TC]   = c.tc;
        w[BIT_MERR] = c.merr;
        w[BIT_AERR] = c.aerr;
        return w;
    endfunction

endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
    import dmac_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int CHW = $clog2(NCH),
    parameter int AW  = CHW + WIN_BITS
) (
    input  logic           wr,
    input  logic [AW-1:0]  addr,
    output logic [NCH-1:0] wr_mode,
    output logic [NCH-1:0] wr_ctrl,
    output logic [NCH-1:0] wr_count,
    output logic [NCH-1:0] wr_addr,
    output logic [CHW-1:0] ch,
    output reg_sel_e       sel
);

    logic unused_low;
    assign unused_low = ^addr[2:0];

    assign ch  = addr[AW-1:WIN_BITS];
    assign sel = reg_sel_e'(addr[4:3]);

    for (genvar g = 0; g < NCH; g++) begin : g_strobe
        logic hit;
        assign hit         = wr && (ch == CHW'(g));
        assign wr_mode[g]  = hit && (sel == SEL_MODE);
        assign wr_ctrl[g]  = hit && (sel == SEL_CTRL);
        assign wr_count[g] = hit && (sel == SEL_COUNT);
        assign wr_addr[g]  = hit && (sel == SEL_ADDR);
    end

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int CNT_W = CNT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mode,
    input  logic              wr_ctrl,
    input  logic              wr_count,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dec,
    input  logic              merr_set,
    input  logic              aerr_set,
    output mode_t             mode_o,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [DATA_W-1:0] addr_o,
    output logic              irq_o
);

    mode_t             mode_q;
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  count_q;
    logic [DATA_W-1:0] addr_q;

    logic dec_take;
    logic last_unit;
    logic [DATA_W-1:0] step;

    // a count write in the same cycle swallows the decrement entirely
    assign dec_take  = dec && ctrl_q.en && (count_q != '0) && !wr_count;
    assign last_unit = dec_take && (count_q == CNT_W'(1));
    assign step      = {{(DATA_W-3){1'b0}}, width_bytes(mode_q.width)};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            ctrl_q  <= '0;
            count_q <= '0;
            addr_q  <= '0;
        end else begin
            if (wr_mode)
                mode_q <= mode_t'(wdata[4:0]);

            if (wr_count)
                count_q <= wdata[CNT_W-1:0];
            else if (dec_take)
                count_q <= count_q - CNT_W'(1);

            if (wr_addr)
                addr_q <= wdata;
            else if (dec_take)
                addr_q <= addr_q + step;

            // hardware terminal clear outranks a software enable write
            if (last_unit)
                ctrl_q.en <= 1'b0;
            else if (wr_ctrl)
                ctrl_q.en <= wdata[BIT_EN];

            if (wr_ctrl)
                ctrl_q.dir <= wdata[BIT_DIR];

            // sticky flags: set beats write-one-to-clear
            ctrl_q.tc   <= last_unit || (ctrl_q.tc   && !(wr_ctrl && wdata[BIT_TC]));
            ctrl_q.merr <= merr_set  || (ctrl_q.merr && !(wr_ctrl && wdata[BIT_MERR]));
            ctrl_q.aerr <= aerr_set  || (ctrl_q.aerr && !(wr_ctrl && wdata[BIT_AERR]));
        end
    end

    assign mode_o  = mode_q;
    assign ctrl_o  = ctrl_q;
    assign count_o = count_q;
    assign addr_o  = addr_q;
    assign irq_o   = mode_q.ie && (ctrl_q.tc || ctrl_q.merr || ctrl_q.aerr);

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int CNT_W = CNT_DEF,
    parameter int CHW   = $clog2(NCH),
    parameter int AW    = CHW + WIN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    dec_evt,
    input  logic [NCH-1:0]    merr_evt,
    input  logic [NCH-1:0]    aerr_evt,
    output logic              irq
);

    logic [NCH-1:0] wr_mode, wr_ctrl, wr_count, wr_addr;
    logic [CHW-1:0] rd_ch;
    reg_sel_e       rd_sel;

    mode_t [NCH-1:0]             mode_v;
    ctrl_t [NCH-1:0]             ctrl_v;
    logic  [NCH-1:0][CNT_W-1:0]  count_v;
    logic  [NCH-1:0][DATA_W-1:0] addr_v;
    logic  [NCH-1:0]             irq_v;

    dmac_decode #(.NCH(NCH), .CHW(CHW), .AW(AW)) u_decode (
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wr_mode  (wr_mode),
        .wr_ctrl  (wr_ctrl),
        .wr_count (wr_count),
        .wr_addr  (wr_addr),
        .ch       (rd_ch),
        .sel      (rd_sel)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmac_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_mode  (wr_mode[g]),
            .wr_ctrl  (wr_ctrl[g]),
            .wr_count (wr_count[g]),
            .wr_addr  (wr_addr[g]),
            .wdata    (bus_wdata),
            .dec      (dec_evt[g]),
            .merr_set (merr_evt[g]),
            .aerr_set (aerr_evt[g]),
            .mode_o   (mode_v[g]),
            .ctrl_o   (ctrl_v[g]),
            .count_o  (count_v[g]),
            .addr_o   (addr_v[g]),
            .irq_o    (irq_v[g])
        );
    end

    always_comb begin
        case (rd_sel)
            SEL_MODE:  bus_rdata = mode_word(mode_v[rd_ch]);
            SEL_CTRL:  bus_rdata = ctrl_word(ctrl_v[rd_ch]);
            SEL_COUNT: bus_rdata = {{(DATA_W-CNT_W){1'b0}}, count_v[rd_ch]};
            default:   bus_rdata = addr_v[rd_ch];
        endcase
    end

    assign irq = |irq_v;

endmodule

// File: rtl/dmac_regfile_checker.sv
module dmac_regfile_checker
    import dmac_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int CNT_W = CNT_DEF
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_wr,
    input logic [NCH-1:0]              dec_evt,
    input logic [NCH-1:0]              merr_evt,
    input logic [NCH-1:0]              aerr_evt,
    input logic                        irq,
    input mode_t [NCH-1:0]             mode_v,
    input ctrl_t [NCH-1:0]             ctrl_v,
    input logic  [NCH-1:0][CNT_W-1:0]  count_v,
    input logic  [NCH-1:0][DATA_W-1:0] addr_v
);

    logic any_req;
    always_comb begin
        any_req = 1'b0;
        for (int k = 0; k < NCH; k++)
            any_req = any_req |
                (mode_v[k].ie & (ctrl_v[k].tc | ctrl_v[k].merr | ctrl_v[k].aerr));
    end

    assert_irq_summary_R10: assert property (@(posedge clk) disable iff (rst)
        irq == any_req);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        logic [2:0] wb_i;
        logic       live_i;
        assign wb_i   = width_bytes(mode_v[i].width);
        assign live_i = dec_evt[i] && ctrl_v[i].en && (count_v[i] != '0) && !bus_wr;

        assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
            live_i |=> count_v[i] == $past(count_v[i]) - CNT_W'(1));

        assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
            live_i |=> addr_v[i] == $past(addr_v[i]) + {{(DATA_W-3){1'b0}}, $past(wb_i)});

        assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (!bus_wr && (!dec_evt[i] || !ctrl_v[i].en)) |=>
                $stable(count_v[i]) && $stable(addr_v[i]));

        assert_terminal_R9: assert property (@(posedge clk) disable iff (rst)
            (live_i && count_v[i] == CNT_W'(1)) |=> ctrl_v[i].tc && !ctrl_v[i].en);

        assert_merr_set_R11: assert property (@(posedge clk) disable iff (rst)
            merr_evt[i] |=> ctrl_v[i].merr);

        assert_aerr_set_R11: assert property (@(posedge clk) disable iff (rst)
            aerr_evt[i] |=> ctrl_v[i].aerr);

        assert_err_keeps_en_R6: assert property (@(posedge clk) disable iff (rst)
            ((merr_evt[i] || aerr_evt[i]) && !bus_wr && !dec_evt[i]) |=>
                ctrl_v[i].en == $past(ctrl_v[i].en));
    end

endmodule

bind dmac_regfile dmac_regfile_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .dec_evt  (dec_evt),
    .merr_evt (merr_evt),
    .aerr_evt (aerr_evt),
    .irq      (irq),
    .mode_v   (mode_v),
    .ctrl_v   (ctrl_v),
    .count_v  (count_v),
    .addr_v   (addr_v)
);

// File: tb/dmac_regfile_bench.sv
module dmac_regfile_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  dec_evt = '0;
    logic [7:0]  merr_evt = '0;
    logic [7:0]  aerr_evt = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dmac_regfile u_dmac_regfile (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dec_evt   (dec_evt),
        .merr_evt  (merr_evt),
        .aerr_evt  (aerr_evt),
        .irq       (irq)
    );

    function automatic logic [7:0] ra(input int ch, input int sel);
        return {ch[2:0], sel[1:0], 3'b000};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [7:0] dec, input logic [7:0] me, input logic [7:0] ae);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        dec_evt = dec; merr_evt = me; aerr_evt = ae;
        @(negedge clk);
        bus_wr = 1'b0; dec_evt = '0; merr_evt = '0; aerr_evt = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state over all registers
        for (int c = 0; c < 8; c++)
            for (int s = 0; s < 4; s++) begin
                rd(ra(c, s), v);
                chk("R1 reset value", v, 32'h0);
            end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R2/R4: fill every channel, read all back
        for (int c = 0; c < 8; c++) begin
            wr(ra(c, 0), 32'(c * 3 + 1) & 32'h1B);
            wr(ra(c, 1), 32'(c & 3));
            wr(ra(c, 2), 32'h1000 + 32'(c));
            wr(ra(c, 3), 32'hA000_0000 + 32'(c) * 32'h111);
        end
        for (int c = 0; c < 8; c++) begin
            rd(ra(c, 0), v); chk("R2 mode map", v, 32'(c * 3 + 1) & 32'h1B);
            rd(ra(c, 1), v); chk("R4 enable/dir map", v, 32'(c & 3));
            rd(ra(c, 2), v); chk("R2 count map", v, 32'h1000 + 32'(c));
            rd(ra(c, 3), v); chk("R2 address map", v, 32'hA000_0000 + 32'(c) * 32'h111);
        end
        rd(ra(4, 2) | 8'h05, v);
        chk("R2 low address bits ignored", v, 32'h1004);
        for (int c = 0; c < 8; c++) begin
            wr(ra(c, 0), 32'h0);
            wr(ra(c, 1), 32'h0);
        end

        // R3 mode sweep, upper bits dropped
        for (int m = 0; m < 32; m++) begin
            wr(ra(3, 0), 32'hFFFF_FFE0 | 32'(m));
            rd(ra(3, 0), v);
            chk("R3 mode field", v, 32'(m));
        end
        wr(ra(3, 0), 32'h0);

        // R7 decrement per width code
        for (int w = 0; w < 4; w++) begin
            int wb;
            wb = (w == 0) ? 1 : (w == 1) ? 2 : 4;
            wr(ra(2, 0), 32'(w) << 3);
            wr(ra(2, 2), 32'd5);
            wr(ra(2, 3), 32'h100);
            wr(ra(2, 1), 32'h1);
            for (int k = 0; k < 3; k++) step(1'b0, 8'h0, 32'h0, 8'h04, 8'h00, 8'h00);
            rd(ra(2, 2), v); chk("R7 residual count", v, 32'd2);
            rd(ra(2, 3), v); chk("R7 address step", v, 32'h100 + 32'(3 * wb));
            rd(ra(2, 1), v); chk("R7 enable kept", v, 32'h1);
        end

        // R8 disabled channel and zero count
        wr(ra(2, 1), 32'h0);
        step(1'b0, 8'h0, 32'h0, 8'h04, 8'h00, 8'h00);
        rd(ra(2, 2), v); chk("R8 disabled count", v, 32'd2);
        rd(ra(2, 3), v); chk("R8 disabled address", v, 32'h10C);
        wr(ra(2, 2), 32'd0);
        wr(ra(2, 1), 32'h1);
        step(1'b0, 8'h0, 32'h0, 8'h04, 8'h00, 8'h00);
        rd(ra(2, 2), v); chk("R8 zero count", v, 32'd0);
        rd(ra(2, 1), v); chk("R8 zero count no flag", v, 32'h1);

        // R9 terminal count
        wr(ra(2, 2), 32'd2);
        step(1'b0, 8'h0, 32'h0, 8'h04, 8'h00, 8'h00);
        step(1'b0, 8'h0, 32'h0, 8'h04, 8'h00, 8'h00);
        rd(ra(2, 2), v); chk("R9 count at zero", v, 32'd0);
        rd(ra(2, 1), v); chk("R9 tc set enable cleared", v, 32'h100);

        // R10 interrupt gating
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        wr(ra(2, 0), 32'h4);
        chk("R10 irq raised", {31'b0, irq}, 32'h1);

        // R5 write-one-to-clear
        wr(ra(2, 1), 32'h0);
        rd(ra(2, 1), v); chk("R5 zero write keeps flag", v, 32'h100);
        wr(ra(2, 1), 32'h100);
        rd(ra(2, 1), v); chk("R5 one clears flag", v, 32'h0);
        chk("R10 irq drops", {31'b0, irq}, 32'h0);
        wr(ra(2, 0), 32'h0);

        // R6 error events
        wr(ra(5, 1), 32'h3);
        step(1'b0, 8'h0, 32'h0, 8'h00, 8'h20, 8'h00);
        rd(ra(5, 1), v); chk("R6 memory error", v, 32'h203);
        step(1'b0, 8'h0, 32'h0, 8'h00, 8'h00, 8'h20);
        rd(ra(5, 1), v); chk("R6 address error", v, 32'h603);
        rd(ra(4, 1), v); chk("R6 neighbour untouched", v, 32'h0);

        // R11 set beats clear in the same cycle
        step(1'b1, ra(5, 1), 32'h603, 8'h00, 8'h20, 8'h00);
        rd(ra(5, 1), v); chk("R11 set wins over clear", v, 32'h203);
        wr(ra(5, 1), 32'h200);
        rd(ra(5, 1), v); chk("R5 clear with enable off", v, 32'h0);

        // R12 software writes against decrement
        wr(ra(6, 0), 32'h08);
        wr(ra(6, 2), 32'd7);
        wr(ra(6, 3), 32'h2000);
        wr(ra(6, 1), 32'h1);
        step(1'b1, ra(6, 2), 32'h40, 8'h40, 8'h00, 8'h00);
        rd(ra(6, 2), v); chk("R12 count write wins", v, 32'h40);
        rd(ra(6, 3), v); chk("R12 no address step", v, 32'h2000);
        step(1'b1, ra(6, 3), 32'h3000, 8'h40, 8'h00, 8'h00);
        rd(ra(6, 3), v); chk("R12 address write wins", v, 32'h3000);
        rd(ra(6, 2), v); chk("R12 count still steps", v, 32'h3F);
        wr(ra(6, 2), 32'd1);
        step(1'b1, ra(6, 1), 32'h1, 8'h40, 8'h00, 8'h00);
        rd(ra(6, 1), v); chk("R12 terminal beats enable write", v, 32'h100);
        rd(ra(6, 2), v); chk("R12 terminal count zero", v, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule